// File: doc/BRIEF.md
# Privilege-Checked CSR Access Unit

This block holds a small set of control and status registers for a processor core. It carries out one atomic read-modify-write access per clock cycle. For each access it decides whether the access is allowed or must be reported as an illegal instruction. The caller presents a 12-bit register address, a 2-bit operation code, a write-enable qualifier, a source operand and the current privilege level.

In the same cycle the block returns the register's value from before the access and the illegal flag. The register update takes effect at the next rising clock edge.

Access rights are decoded from the upper address bits and are not kept in a table:

- Bits [11:10] = 11 mean the register is read-only.
- Bits [9:8] give the lowest privilege level that may reach the register.

On top of that decode sit three further rules:

- A per-register write mask keeps some bits fixed.
- One counter store is reachable through two addresses: a read-only view for user level and a read/write view for machine level.
- The window 0x7A0 to 0x7BF is reserved for debug and is refused to machine mode.

Top module: `csrAccessUnit`

## Requirements
- R1: `illegal` and `rdData` are combinational from the current inputs. `rdData` holds the register value from before the access. Any update is visible from the next rising clock edge onward.
- R2: The operation codes are:
  - 01 replaces the value with `srcData`.
  - 10 ORs `srcData` into the value.
  - 11 ANDs the value with the inverse of `srcData`.
  - 00 only reads.
- R3: With `wrEn` low, codes 10 and 11 only read. Such an access to a read-only address does not raise `illegal`. Code 01 always attempts a write, whatever the level of `wrEn`.
- R4: The implemented addresses are listed below. Any other address raises `illegal`.

  | Address | Register |
  |---|---|
  | 0x040 | user scratch |
  | 0x140 | supervisor scratch |
  | 0x340 | machine scratch |
  | 0x300 | machine config |
  | 0xC00 | counter, read-only user view |
  | 0xB00 | counter, read/write machine view |
  | 0xF11 | machine constant identifier |

- R5: Privilege is encoded as 00 user, 01 supervisor, 11 machine. An access raises `illegal` when `curPriv` is numerically below address bits [9:8]. An access with `curPriv` = 10 always raises `illegal`.
- R6: A write attempt to an address with bits [11:10] = 11 raises `illegal`.
- R7: In the config register only the bits set in mask 0x0000F0F0 are writable. All other bits keep their reset value of 0x00000A05.
- R8: A machine-mode access to any address from 0x7A0 to 0x7BF raises `illegal`.
- R9: Addresses 0xC00 and 0xB00 refer to the same counter storage. A write through 0xB00 is read back through 0xC00.
- R10: An illegal access changes no register, and `rdData` reads zero while `illegal` is high.
- R11: After reset, the scratch registers and the counter read 0, the config register reads 0x00000A05, and the identifier reads 0x5EED0001.
- R12: With `accValid` low, `illegal` stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| csrAddr | input | 12 | Register address |
| csrOp | input | 2 | Operation code (00 read, 01 write, 10 set, 11 clear) |
| wrEn | input | 1 | Write qualifier for set and clear |
| srcData | input | 32 | Source operand |
| curPriv | input | 2 | Current privilege level |
| rdData | output | 32 | Value before the access, zero when illegal |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
A read-only sweep over all 4096 addresses at machine level separates implemented addresses from holes and the debug window.

A second sweep crosses the four privilege codes, the implemented addresses, the debug window edges, all four operation codes and both `wrEn` levels. It uses varying operands. This exposes mistakes in the privilege comparison, the read-only write check and the `wrEn` qualification, and tells write, set and clear apart by their read-back values.

Targeted sequences check:

- the shared counter across its two addresses;
- the config write mask, by writing all ones and all zeros;
- that an idle cycle carrying a write operation leaves state untouched.

// File: rtl/csrPkg.sv
package csrPkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csrOpT;

  localparam int NSTORE = 5;
  localparam int IDXW   = 3;

  localparam int IDX_USCR = 0;
  localparam int IDX_SSCR = 1;
  localparam int IDX_MSCR = 2;
  localparam int IDX_CFG  = 3;
  localparam int IDX_CNT  = 4;

  localparam logic [11:0] ADDR_USCR   = 12'h040;
  localparam logic [11:0] ADDR_SSCR   = 12'h140;
  localparam logic [11:0] ADDR_MSCR   = 12'h340;
  localparam logic [11:0] ADDR_CFG    = 12'h300;
  localparam logic [11:0] ADDR_CNT_RO = 12'hC00;
  localparam logic [11:0] ADDR_CNT_RW = 12'hB00;
  localparam logic [11:0] ADDR_ID     = 12'hF11;

  localparam logic [11:0] DBG_LO = 12'h7A0;
  localparam logic [11:0] DBG_HI = 12'h7BF;

  localparam logic [1:0] PRIV_RSVD    = 2'b10;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef struct packed {
    logic [NSTORE-1:0] sel;
    logic              doWrite;
    csrOpT             op;
  } csrStrobeT;

  typedef struct packed {
    logic            hit;
    logic            isConst;
    logic [IDXW-1:0] idx;
  } csrMapT;

  function automatic csrMapT csrLookup(input logic [11:0] a);
    csrMapT m;
    m = '{hit: 1'b1, isConst: 1'b0, idx: '0};
    case (a)
      ADDR_USCR:   m.idx = IDXW'(IDX_USCR);
      ADDR_SSCR:   m.idx = IDXW'(IDX_SSCR);
      ADDR_MSCR:   m.idx = IDXW'(IDX_MSCR);
      ADDR_CFG:    m.idx = IDXW'(IDX_CFG);
      ADDR_CNT_RO: m.idx = IDXW'(IDX_CNT);
      ADDR_CNT_RW: m.idx = IDXW'(IDX_CNT);
      ADDR_ID:     m.isConst = 1'b1;
      default:     m.hit = 1'b0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/csrCtrl.sv
module csrCtrl
  import csrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic [11:0] csrAddr,
  input  logic [1:0]  opIn,
  input  logic        wrEn,
  input  logic [1:0]  curPriv,
  output logic        illegal,
  output logic        constSel,
  output csrStrobeT   stb
);

  csrOpT  op;
  csrMapT map;
  logic   writeTry;
  logic   roAddr;
  logic   privBad;
  logic   inDebug;
  logic   dbgBad;
  logic   grant;

  always_comb begin
    op       = csrOpT'(opIn);
    map      = csrLookup(csrAddr);
    writeTry = (op == OP_WRITE) || (((op == OP_SET) || (op == OP_CLEAR)) && wrEn);
    roAddr   = (csrAddr[11:10] == 2'b11);
    privBad  = (curPriv == PRIV_RSVD) || (curPriv < csrAddr[9:8]);
    inDebug  = (csrAddr >= DBG_LO) && (csrAddr <= DBG_HI);
    dbgBad   = inDebug && (curPriv == PRIV_MACHINE);
    illegal  = accValid && (!map.hit || privBad || (roAddr && writeTry) || dbgBad);
    grant    = accValid && !illegal;
    constSel = grant && map.hit && map.isConst;
  end

  assign stb.doWrite = grant && writeTry;
  assign stb.op      = op;

  for (genvar i = 0; i < NSTORE; i++) begin : gSel
    assign stb.sel[i] = grant && map.hit && !map.isConst && (map.idx == IDXW'(i));
  end

  AST_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (curPriv < csrAddr[9:8])) |-> illegal);  // R5
  AST_RSVD_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (curPriv == PRIV_RSVD)) |-> illegal);  // R5
  AST_RO_WRITE_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (csrAddr[11:10] == 2'b11) && (opIn == 2'd1)) |-> illegal);  // R6
  AST_DEBUG_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (curPriv == PRIV_MACHINE) && (csrAddr >= DBG_LO) && (csrAddr <= DBG_HI)) |-> illegal);  // R8
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.sel));  // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!illegal && !stb.doWrite && (stb.sel == '0)));  // R12
  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!stb.doWrite && (stb.sel == '0) && !constSel));  // R10

endmodule

// File: rtl/csrDatapath.sv
module csrDatapath
  import csrPkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] CFG_WMASK = 32'h0000_F0F0,
  parameter logic [XLEN-1:0] CFG_RESET = 32'h0000_0A05,
  parameter logic [XLEN-1:0] ID_VALUE  = 32'h5EED_0001
) (
  input  logic            clk,
  input  logic            rstN,
  input  csrStrobeT       stb,
  input  logic            constSel,
  input  logic [XLEN-1:0] srcData,
  output logic [XLEN-1:0] rdData
);

  localparam logic [XLEN-1:0] FULL_MASK = '1;

  logic [XLEN-1:0] regQ [NSTORE];

  for (genvar i = 0; i < NSTORE; i++) begin : gReg
    localparam logic [XLEN-1:0] WMASK = (i == IDX_CFG) ? CFG_WMASK : FULL_MASK;
    localparam logic [XLEN-1:0] RSTV  = (i == IDX_CFG) ? CFG_RESET : '0;

    logic [XLEN-1:0] q;
    logic [XLEN-1:0] newVal;

    always_comb begin
      case (stb.op)
        OP_WRITE: newVal = srcData;
        OP_SET:   newVal = q | srcData;
        OP_CLEAR: newVal = q & ~srcData;
        default:  newVal = q;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= RSTV;
      end else if (stb.sel[i] && stb.doWrite) begin
        q <= (q & ~WMASK) | (newVal & WMASK);
      end
    end

    assign regQ[i] = q;
  end

  always_comb begin
    rdData = constSel ? ID_VALUE : '0;
    for (int i = 0; i < NSTORE; i++) begin
      if (stb.sel[i]) rdData = rdData | regQ[i];
    end
  end

  AST_CFG_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    ((regQ[IDX_CFG] & ~CFG_WMASK) == (CFG_RESET & ~CFG_WMASK)));  // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.doWrite && stb.sel[IDX_CNT]) |=> $stable(regQ[IDX_CNT]));  // R10
  AST_MSCR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.doWrite && stb.sel[IDX_MSCR]) |=> $stable(regQ[IDX_MSCR]));  // R12

endmodule

// File: rtl/csrAccessUnit.sv
module csrAccessUnit
  import csrPkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] CFG_WMASK = 32'h0000_F0F0,
  parameter logic [XLEN-1:0] CFG_RESET = 32'h0000_0A05,
  parameter logic [XLEN-1:0] ID_VALUE  = 32'h5EED_0001
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [11:0]     csrAddr,
  input  logic [1:0]      csrOp,
  input  logic            wrEn,
  input  logic [XLEN-1:0] srcData,
  input  logic [1:0]      curPriv,
  output logic [XLEN-1:0] rdData,
  output logic            illegal
);

  csrStrobeT stb;
  logic      constSel;

  csrCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .csrAddr  (csrAddr),
    .opIn     (csrOp),
    .wrEn     (wrEn),
    .curPriv  (curPriv),
    .illegal  (illegal),
    .constSel (constSel),
    .stb      (stb)
  );

  csrDatapath #(
    .XLEN      (XLEN),
    .CFG_WMASK (CFG_WMASK),
    .CFG_RESET (CFG_RESET),
    .ID_VALUE  (ID_VALUE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .constSel (constSel),
    .srcData  (srcData),
    .rdData   (rdData)
  );

  AST_TRAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (rdData == '0));  // R10

endmodule

// File: tb/csrAccessUnit_tb.sv
module csrAccessUnit_tb;

  localparam logic [31:0] CFG_M   = 32'h0000_F0F0;
  localparam logic [31:0] CFG_R   = 32'h0000_0A05;
  localparam logic [31:0] ID_V    = 32'h5EED_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0]  csrOp = '0;
  logic        wrEn = 1'b0;
  logic [31:0] srcData = '0;
  logic [1:0]  curPriv = 2'b11;
  logic [31:0] rdData;
  logic        illegal;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] expQ [5];

  always #2 clk = ~clk;

  csrAccessUnit u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .csrAddr(csrAddr),
    .csrOp(csrOp), .wrEn(wrEn), .srcData(srcData), .curPriv(curPriv),
    .rdData(rdData), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int idxOf(input logic [11:0] a);
    case (a)
      12'h040: return 0;
      12'h140: return 1;
      12'h340: return 2;
      12'h300: return 3;
      12'hC00, 12'hB00: return 4;
      12'hF11: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic bit isDbg(input logic [11:0] a);
    return (a >= 12'h7A0) && (a <= 12'h7BF);
  endfunction

  function automatic bit writeTry(input logic [1:0] op, input logic w);
    return (op == 2'd1) || ((op >= 2'd2) && w);
  endfunction

  function automatic bit expIll(input logic [11:0] a, input logic [1:0] op,
                                input logic w, input logic [1:0] p);
    return (idxOf(a) < 0) || (p == 2'b10) || (p < a[9:8]) ||
           ((a[11:10] == 2'b11) && writeTry(op, w)) || ((p == 2'b11) && isDbg(a));
  endfunction

  function automatic string illTag(input logic [11:0] a, input logic [1:0] op,
                                   input logic w, input logic [1:0] p);
    if (isDbg(a)) return "R8";
    if (idxOf(a) < 0) return "R4";
    if ((p == 2'b10) || (p < a[9:8])) return "R5";
    if ((a[11:10] == 2'b11) && writeTry(op, w)) return "R6";
    return "R3";
  endfunction

  task automatic acc(input logic [11:0] a, input logic [1:0] op, input logic w,
                     input logic [31:0] s, input logic [1:0] p);
    int k;
    bit ill;
    logic [31:0] expRd, m, nv, old;
    @(negedge clk);
    accValid = 1'b1; csrAddr = a; csrOp = op; wrEn = w; srcData = s; curPriv = p;
    #1;
    k   = idxOf(a);
    ill = expIll(a, op, w, p);
    if (ill) expRd = '0;
    else if (k == 5) expRd = ID_V;
    else expRd = expQ[k];
    chk(illTag(a, op, w, p), {31'd0, illegal}, {31'd0, ill});
    chk(ill ? "R10" : "R1", rdData, expRd);
    @(posedge clk);
    if (!ill && writeTry(op, w) && (k >= 0) && (k < 5)) begin
      old = expQ[k];
      m = (k == 3) ? CFG_M : 32'hFFFF_FFFF;
      case (op)
        2'd1: nv = s;
        2'd2: nv = old | s;
        default: nv = old & ~s;
      endcase
      expQ[k] = (old & ~m) | (nv & m);
    end
    #1 accValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [9];
    logic [31:0] pat;
    addrs = '{12'h040, 12'h140, 12'h340, 12'h300, 12'hC00, 12'hB00, 12'hF11, 12'h7A0, 12'h7BF};
    expQ = '{32'd0, 32'd0, 32'd0, CFG_R, 32'd0};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R11: reset values, machine level reads
    for (int i = 0; i < 7; i++) acc(addrs[i], 2'd0, 1'b0, 32'd0, 2'b11);
    @(negedge clk);
    chk("R12", {31'd0, illegal}, 32'd0);
    // R4 / R8: full address sweep, read only at machine level
    for (int a = 0; a < 4096; a++) acc(12'(a), 2'd0, 1'b0, 32'hFFFF_FFFF, 2'b11);
    // R2 / R3 / R5 / R6: cross sweep
    pat = 32'h1357_9BDF;
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 9; i++)
        for (int op = 0; op < 4; op++)
          for (int w = 0; w < 2; w++) begin
            pat = pat * 32'h9E37_79B9 + 32'h7F4A_7C15;
            acc(addrs[i], 2'(op), 1'(w), pat, 2'(p));
          end
    // R9: shared counter
    acc(12'hB00, 2'd1, 1'b1, 32'hCAFE_0042, 2'b11);
    acc(12'hC00, 2'd0, 1'b0, 32'd0, 2'b00);
    chk("R9", expQ[4], 32'hCAFE_0042);
    acc(12'hC00, 2'd1, 1'b1, 32'h1111_1111, 2'b11);
    acc(12'hB00, 2'd3, 1'b1, 32'h0000_0042, 2'b11);
    acc(12'hC00, 2'd2, 1'b0, 32'hFFFF_FFFF, 2'b00);
    // R7: config mask
    acc(12'h300, 2'd1, 1'b1, 32'hFFFF_FFFF, 2'b11);
    acc(12'h300, 2'd0, 1'b0, 32'd0, 2'b11);
    chk("R7", expQ[3], 32'h0000_FAF5);
    acc(12'h300, 2'd1, 1'b1, 32'h0000_0000, 2'b11);
    acc(12'h300, 2'd0, 1'b0, 32'd0, 2'b11);
    chk("R7", expQ[3], 32'h0000_0A05);
    // R12: idle cycle carrying a write
    acc(12'h340, 2'd1, 1'b1, 32'hA5A5_0001, 2'b11);
    @(negedge clk);
    accValid = 1'b0; csrAddr = 12'h340; csrOp = 2'd1; wrEn = 1'b1;
    srcData = 32'h0BAD_0BAD; curPriv = 2'b11;
    #1 chk("R12", {31'd0, illegal}, 32'd0);
    @(posedge clk);
    acc(12'h340, 2'd0, 1'b0, 32'd0, 2'b11);
    chk("R12", expQ[2], 32'hA5A5_0001);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule